// File: doc/BRIEF.md
# Dual-Strobe Up/Down Presettable Counter

This block is a small binary counter whose direction is chosen by which of two active-low count strobes is pulsed, rather than by a direction pin. A pulse on the up strobe adds one and a pulse on the down strobe subtracts one. The step is taken when the strobe is released, and only if the other strobe is held high at the time. An active-high clear forces the count to zero and beats everything else. An active-low load copies the parallel data input into the count, whatever the strobes are doing. All bits change together on the same clock edge.

All inputs are sampled on one system clock through a two-stage synchronizer. The strobe release edges are found by comparing the newest synchronized sample with the one before it. The carry and borrow outputs are active low. Carry follows the synchronized up strobe while the count is at its maximum. Borrow follows the synchronized down strobe while the count is zero. Feeding carry into the up strobe of the next stage, and borrow into its down strobe, builds a wider counter with no extra logic. Presetting a start value through load turns the block into a modulo-N divider.

Top module: `updn_strobe_counter`

## Requirements
- R1: While rst_n is low, and after it is released with idle inputs, q is 0 and carry_n and borrow_n are 1.
- R2: A low-then-high pulse on up_n while dn_n stays high increments q by one. The new value appears on the third rising clk edge after up_n goes high: two edges for sampling, one for the update.
- R3: A low-then-high pulse on dn_n while up_n stays high decrements q by one, with the same three-edge latency as R2.
- R4: Counting wraps from 15 to 0 going up and from 0 to 15 going down, so sixteen up pulses return q to its start value.
- R5: When up_n and dn_n are low together, releasing one of them while the other is still low leaves q unchanged. Releasing both in the same cycle also leaves q unchanged.
- R6: While load_n is low, q takes the sampled value of d, and strobe pulses have no effect on q.
- R7: While clr is high, q becomes 0, overriding load_n and the strobes.
- R8: carry_n is 0 exactly when the synchronized up_n is low and q is 15; otherwise it is 1.
- R9: borrow_n is 0 exactly when the synchronized dn_n is low and q is 0; otherwise it is 1.
- R10: Holding a strobe low, or its falling edge, causes no count. Only the release counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_n | input | 1 | Active-low up-count strobe; counts on release |
| dn_n | input | 1 | Active-low down-count strobe; counts on release |
| load_n | input | 1 | Active-low parallel preset enable |
| clr | input | 1 | Active-high clear, highest priority |
| d | input | 4 | Preset value |
| q | output | 4 | Count value |
| carry_n | output | 1 | Active-low overflow pulse for cascading |
| borrow_n | output | 1 | Active-low underflow pulse for cascading |

## Verification
The bench drives wraps in both directions. A design that saturated there, or that lost the carry across the boundary, would stick at 15 or 0. It overlaps the two strobes and releases them in turn, which catches a design that steps on any release regardless of the other strobe. It also holds a strobe low for many cycles, which exposes a design that counts on the falling edge or on level. Loads and clears are issued while strobes are pulsing, so a wrong priority order shows up as a stepped or preset value where a fixed one is expected. The carry and borrow outputs are compared against the model every cycle, which flags outputs that fire away from the terminal count or that miss the strobe window.

// File: rtl/updn_strobe_counter.sv
module updn_strobe_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_n,
  input  logic             dn_n,
  input  logic             load_n,
  input  logic             clr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic [2:0]       up_s, dn_s;
  logic [1:0]       ld_s, clr_s;
  logic [WIDTH-1:0] d_s1, d_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_s  <= '1;
      dn_s  <= '1;
      ld_s  <= '1;
      clr_s <= '0;
      d_s1  <= '0;
      d_s2  <= '0;
    end else begin
      up_s  <= {up_s[1:0], up_n};
      dn_s  <= {dn_s[1:0], dn_n};
      ld_s  <= {ld_s[0], load_n};
      clr_s <= {clr_s[0], clr};
      d_s1  <= d;
      d_s2  <= d_s1;
    end
  end

  wire up_rise = up_s[1] & ~up_s[2];
  wire dn_rise = dn_s[1] & ~dn_s[2];
  wire step_up = up_rise & dn_s[1] & ~dn_rise;
  wire step_dn = dn_rise & up_s[1] & ~up_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (clr_s[1]) q <= '0;
    else if (!ld_s[1]) q <= d_s2;
    else if (step_up)  q <= q + 1'b1;
    else if (step_dn)  q <= q - 1'b1;
  end

  assign carry_n  = ~(~up_s[1] & (q == TOP));
  assign borrow_n = ~(~dn_s[1] & (q == '0));
endmodule

// File: rtl/updn_strobe_counter_chk.sv
module updn_strobe_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up_n,
  input logic             dn_n,
  input logic             load_n,
  input logic             clr,
  input logic [WIDTH-1:0] d,
  input logic [WIDTH-1:0] q,
  input logic             carry_n,
  input logic             borrow_n
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 3'd5) age <= age + 1'b1;
  wire warm = (age == 3'd5);

  p_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (q == {WIDTH{1'b1}}));
  p_borrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> (q == '0));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(clr, 3)) |-> (q == '0));
  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(load_n, 3) && !$past(clr, 3)) |-> (q == $past(d, 3)));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(clr, 3) && $past(load_n, 3) && $past(up_n, 3) == $past(up_n, 4)
     && $past(dn_n, 3) == $past(dn_n, 4)) |-> $stable(q));
endmodule

bind updn_strobe_counter updn_strobe_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_n(up_n), .dn_n(dn_n), .load_n(load_n),
  .clr(clr), .d(d), .q(q), .carry_n(carry_n), .borrow_n(borrow_n));

// File: tb/updn_strobe_counter_tb.sv
module updn_strobe_counter_tb;
  logic clk = 0, rst_n = 0;
  logic up_n = 1, dn_n = 1, load_n = 1, clr = 0;
  logic [3:0] d = 0;
  logic [3:0] q;
  logic carry_n, borrow_n;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  updn_strobe_counter u_dut (.clk(clk), .rst_n(rst_n), .up_n(up_n), .dn_n(dn_n),
    .load_n(load_n), .clr(clr), .d(d), .q(q), .carry_n(carry_n), .borrow_n(borrow_n));

  // behavioural reference: inputs remembered per edge, newest at index 0
  bit up_h[$], dn_h[$], ld_h[$], cl_h[$];
  int d_h[$];
  int mq = 0;
  bit m_up2 = 1, m_dn2 = 1;

  task automatic model_reset();
    up_h = {1, 1, 1}; dn_h = {1, 1, 1}; ld_h = {1, 1}; cl_h = {0, 0}; d_h = {0, 0};
    mq = 0; m_up2 = 1; m_dn2 = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit ur, dr;
      ur = up_h[1] && !up_h[2];
      dr = dn_h[1] && !dn_h[2];
      if (cl_h[1]) mq = 0;
      else if (!ld_h[1]) mq = d_h[1];
      else if (ur && dn_h[1] && !dr) mq = (mq + 1) % 16;
      else if (dr && up_h[1] && !ur) mq = (mq + 15) % 16;
      up_h.push_front(up_n); void'(up_h.pop_back());
      dn_h.push_front(dn_n); void'(dn_h.pop_back());
      ld_h.push_front(load_n); void'(ld_h.pop_back());
      cl_h.push_front(clr); void'(cl_h.pop_back());
      d_h.push_front(int'(d)); void'(d_h.pop_back());
      m_up2 = up_h[1]; m_dn2 = dn_h[1];
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2/R3 model q", int'(q), mq);
    chk("R8 model carry_n", int'(carry_n), (!m_up2 && mq == 15) ? 0 : 1);
    chk("R9 model borrow_n", int'(borrow_n), (!m_dn2 && mq == 0) ? 0 : 1);
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up(int len);
    up_n = 0; tick(len); up_n = 1; tick(4);
  endtask

  task automatic pulse_dn(int len);
    dn_n = 0; tick(len); dn_n = 1; tick(4);
  endtask

  task automatic run();
    model_reset();
    tick(3);
    chk("R1 q in reset", int'(q), 0);
    rst_n = 1; tick(4);
    chk("R1 q after reset", int'(q), 0);
    chk("R1 carry_n", int'(carry_n), 1);
    chk("R1 borrow_n", int'(borrow_n), 1);
    d = 5; load_n = 0; tick(4);
    chk("R6 load", int'(q), 5);
    pulse_up(3);
    chk("R6 strobe ignored during load", int'(q), 5);
    load_n = 1; tick(4);
    pulse_up(2);
    chk("R2 up step", int'(q), 6);
    up_n = 0; tick(8);
    chk("R10 held low no count", int'(q), 6);
    up_n = 1; tick(4);
    chk("R2 release counts", int'(q), 7);
    pulse_dn(2); pulse_dn(5);
    chk("R3 down steps", int'(q), 5);
    d = 15; load_n = 0; tick(4); load_n = 1; tick(4);
    up_n = 0; tick(4);
    chk("R8 carry at 15", int'(carry_n), 0);
    up_n = 1; tick(4);
    chk("R4 wrap up", int'(q), 0);
    chk("R8 carry released", int'(carry_n), 1);
    dn_n = 0; tick(4);
    chk("R9 borrow at 0", int'(borrow_n), 0);
    dn_n = 1; tick(4);
    chk("R4 wrap down", int'(q), 15);
    up_n = 0; tick(2); dn_n = 0; tick(3);
    up_n = 1; tick(4);
    chk("R5 release with other low", int'(q), 15);
    dn_n = 1; tick(4);
    chk("R5 later release counts", int'(q), 14);
    up_n = 0; dn_n = 0; tick(3); up_n = 1; dn_n = 1; tick(4);
    chk("R5 simultaneous release", int'(q), 14);
    clr = 1; load_n = 0; d = 9; tick(1);
    up_n = 0; tick(2); up_n = 1; tick(4);
    chk("R7 clear over load and count", int'(q), 0);
    clr = 0; tick(4);
    chk("R6 load after clear", int'(q), 9);
    load_n = 1; tick(4);
    for (int i = 0; i < 16; i++) pulse_up(1 + i % 3);
    chk("R4 sixteen ups return", int'(q), 9);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule